// File: doc/BRIEF.md
# One-Wire Bus Master Slot Engine

This block is the timing engine of a master on a single open-drain one-wire line. It carries out one of four bus operations at a time: a reset with presence detection, a write-one slot, a write-zero slot, or a read slot. It pulls the line low through an output enable and otherwise leaves it to an external pull-up. The returned line level passes through a two-flop synchroniser, and every sampling decision uses the synchronised level.

All slot timings are counted in microseconds. A clock divider with a parameterised ratio produces the microsecond tick. The divider restarts each time a command is accepted, so every interval is measured from the first clock of the slot. The ten timing values sit in a small bank that loads defaults at reset and can be rewritten while the engine is idle.

Commands enter through a valid/ready handshake. `cmd_ready` is high only while the engine is idle, and a command stays pending for as long as `cmd_valid` is held against a low `cmd_ready`. Completion is reported by a one-clock `done` pulse. At that pulse the result flags for the finished command are valid, and they hold until a later command of the same kind updates them.

Top module: `ow_master`

## Requirements
- R1: A write-one command (`cmd_op` = 1) asserts `ow_oe` for exactly tLOW1 µs from the clock after acceptance, releases the line, and raises `done` (tSLOT + tREC) µs after acceptance. One µs is CLKS_PER_US clocks.
- R2: A write-zero command (`cmd_op` = 2) asserts `ow_oe` for exactly tLOW0 µs and raises `done` (tSLOT + tREC) µs after acceptance.
- R3: A read command (`cmd_op` = 3) asserts `ow_oe` for tLOWR µs. It then samples the line until the line is high or (tRDV + 2) µs have passed since acceptance. `rd_bit` becomes 1 if the high level was seen before tRDV µs had elapsed, and 0 otherwise.
- R4: A read command raises `done` (tSLOT + tREC) µs after acceptance, however early the line rose.
- R5: A reset command (`cmd_op` = 0) accepted while the synchronised line is low never asserts `ow_oe`. It raises `done` in the clock after acceptance with `bus_fault` = 1 and `presence` = 0.
- R6: A reset command on a high line asserts `ow_oe` for tRSTL µs. At (tRSTL + tPDH + tPDL/2) µs it samples the line, and a low level there means a device is present. It raises `done` at (tRSTL + tRSTH) µs.
- R7: If the line is low at the end of the reset window, that reset ends with `bus_fault` = 1 and `presence` = 0. Otherwise `bus_fault` = 0.
- R8: `cmd_ready` is high exactly while the engine is idle, and a command is taken on a clock where `cmd_valid` and `cmd_ready` are both high. `done` lasts exactly one clock, coincides with `cmd_ready` returning high, and `ow_oe` is never asserted while `cmd_ready` is high.
- R9: After reset the timing bank holds tSLOT=65, tLOW1=8, tLOW0=60, tREC=5, tLOWR=5, tRDV=15, tRSTL=480, tPDH=15, tPDL=60 and tRSTH=480. Write index 0 selects tSLOT, 1 tLOW1, 2 tLOW0, 3 tREC, 4 tLOWR, 5 tRDV, 6 tRSTL, 7 tPDH, 8 tPDL and 9 tRSTH. A write while idle takes effect from the next command.
- R10: A timing write presented while a command is in progress is discarded and has no effect on that command or on later ones.
- R11: While `rst_n` is low and just after it rises, `ow_oe`, `done`, `rd_bit`, `presence` and `bus_fault` are 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_op | input | 2 | 0 reset, 1 write one, 2 write zero, 3 read |
| tim_we | input | 1 | Timing bank write strobe |
| tim_sel | input | 4 | Timing register index (R9) |
| tim_val | input | TW | Timing value in µs |
| done | output | 1 | One-clock completion pulse |
| rd_bit | output | 1 | Bit returned by the last read |
| presence | output | 1 | Device answered the last reset |
| bus_fault | output | 1 | Last reset found the line stuck low |
| ow_oe | output | 1 | Pull the line low when high |
| ow_in | input | 1 | Level seen on the line |

## Verification
The bench builds the engine with CLKS_PER_US = 4 and TW = 16. The short divider keeps a full reset sequence at default timing under four thousand clocks, so every command kind, both reset fault checks and the read decision on either side of tRDV all run with the reset-time timing values. Because one µs is only four clocks, the bench can count pulse widths and completion times to the exact clock. A behavioural device model on the line holds it low over programmable windows, and a separate force input imitates a shorted bus.

// File: rtl/ow_pkg.sv
package ow_pkg;

  localparam int NUM_TIM = 10;

  // timing bank indices
  localparam int TI_SLOT = 0;
  localparam int TI_LOW1 = 1;
  localparam int TI_LOW0 = 2;
  localparam int TI_REC  = 3;
  localparam int TI_LOWR = 4;
  localparam int TI_RDV  = 5;
  localparam int TI_RSTL = 6;
  localparam int TI_PDH  = 7;
  localparam int TI_PDL  = 8;
  localparam int TI_RSTH = 9;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WR1   = 2'd1,
    OP_WR0   = 2'd2,
    OP_READ  = 2'd3
  } ow_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOW   = 3'd1,
    ST_REL   = 3'd2,
    ST_RSAMP = 3'd3,
    ST_RWAIT = 3'd4,
    ST_PD    = 3'd5,
    ST_TAIL  = 3'd6
  } ow_state_e;

  function automatic int tim_default(input int idx);
    case (idx)
      TI_SLOT: return 65;
      TI_LOW1: return 8;
      TI_LOW0: return 60;
      TI_REC:  return 5;
      TI_LOWR: return 5;
      TI_RDV:  return 15;
      TI_RSTL: return 480;
      TI_PDH:  return 15;
      TI_PDL:  return 60;
      TI_RSTH: return 480;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/ow_us_tick.sv
module ow_us_tick #(
  parameter int CLKS_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int DW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLKS_PER_US - 1);

  logic [DW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = !clr && (cnt == LAST);
endmodule

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  // idle line is high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], din};
  end

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/ow_timing_regs.sv
module ow_timing_regs #(
  parameter int TW = 16,
  parameter int NT = ow_pkg::NUM_TIM,
  parameter int SW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [SW-1:0]          wr_sel,
  input  logic [TW-1:0]          wr_val,
  output logic [NT-1:0][TW-1:0]  tim
);
  for (genvar g = 0; g < NT; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tim[g] <= TW'(ow_pkg::tim_default(g));
      else if (wr_en && (wr_sel == SW'(g)))
        tim[g] <= wr_val;
    end
  end
endmodule

// File: rtl/ow_slot_ctrl.sv
module ow_slot_ctrl
  import ow_pkg::*;
#(
  parameter int TW = 16,
  parameter int NT = NUM_TIM
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [1:0]            cmd_op,
  input  logic                  tick,
  input  logic                  line_s,
  input  logic [NT-1:0][TW-1:0] tim,
  output logic                  idle,
  output logic                  drive_low,
  output logic                  done,
  output logic                  rd_bit,
  output logic                  presence,
  output logic                  bus_fault
);
  localparam int EW = TW + 2;
  localparam logic [EW-1:0] EL_MAX = '1;

  ow_state_e     state;
  ow_op_e        op_q;
  logic [EW-1:0] el;
  logic [EW-1:0] el_nxt;
  logic          rd_q;
  logic          pd_q;

  logic [EW-1:0] low_thr, slot_end, rdv_thr, rdv_lim, pd_thr, rst_end;

  assign el_nxt = el + {{(EW-1){1'b0}}, (tick && el != EL_MAX)};

  always_comb begin
    case (op_q)
      OP_WR1:  low_thr = EW'(tim[TI_LOW1]);
      OP_WR0:  low_thr = EW'(tim[TI_LOW0]);
      OP_READ: low_thr = EW'(tim[TI_LOWR]);
      default: low_thr = EW'(tim[TI_RSTL]);
    endcase
    slot_end = EW'(tim[TI_SLOT]) + EW'(tim[TI_REC]);
    rdv_thr  = EW'(tim[TI_RDV]);
    rdv_lim  = EW'(tim[TI_RDV]) + EW'(2);
    pd_thr   = EW'(tim[TI_RSTL]) + EW'(tim[TI_PDH]) + (EW'(tim[TI_PDL]) >> 1);
    rst_end  = EW'(tim[TI_RSTL]) + EW'(tim[TI_RSTH]);
  end

  assign idle      = (state == ST_IDLE);
  assign drive_low = (state == ST_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      op_q      <= OP_RESET;
      el        <= '0;
      rd_q      <= 1'b0;
      pd_q      <= 1'b0;
      done      <= 1'b0;
      rd_bit    <= 1'b0;
      presence  <= 1'b0;
      bus_fault <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) el <= '0;
      else                  el <= el_nxt;

      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q <= ow_op_e'(cmd_op);
            if (ow_op_e'(cmd_op) == OP_RESET && !line_s) begin
              // line already low: refuse to drive it
              done      <= 1'b1;
              bus_fault <= 1'b1;
              presence  <= 1'b0;
            end else begin
              state <= ST_LOW;
            end
          end
        end
        ST_LOW: begin
          if (el_nxt >= low_thr) begin
            case (op_q)
              OP_RESET: state <= ST_PD;
              OP_READ:  state <= ST_RSAMP;
              default:  state <= ST_REL;
            endcase
          end
        end
        ST_REL: begin
          if (el_nxt >= slot_end) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        ST_RSAMP: begin
          if (line_s) begin
            rd_q  <= (el < rdv_thr);
            state <= ST_RWAIT;
          end else if (el_nxt >= rdv_lim) begin
            rd_q  <= 1'b0;
            state <= ST_RWAIT;
          end
        end
        ST_RWAIT: begin
          if (el_nxt >= slot_end) begin
            rd_bit <= rd_q;
            state  <= ST_IDLE;
            done   <= 1'b1;
          end
        end
        ST_PD: begin
          if (el_nxt >= pd_thr) begin
            pd_q  <= !line_s;
            state <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (el_nxt >= rst_end) begin
            bus_fault <= !line_s;
            presence  <= pd_q && line_s;
            state     <= ST_IDLE;
            done      <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ow_master.sv
module ow_master #(
  parameter int CLKS_PER_US = 100,
  parameter int TW          = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic          tim_we,
  input  logic [3:0]    tim_sel,
  input  logic [TW-1:0] tim_val,
  output logic          done,
  output logic          rd_bit,
  output logic          presence,
  output logic          bus_fault,
  output logic          ow_oe,
  input  logic          ow_in
);
  localparam int NT = ow_pkg::NUM_TIM;

  logic                  line_s;
  logic                  tick;
  logic                  idle;
  logic [NT-1:0][TW-1:0] tim;

  ow_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ow_in), .dout(line_s)
  );

  ow_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(idle), .tick(tick)
  );

  ow_timing_regs #(.TW(TW), .NT(NT), .SW(4)) u_tim (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tim_we && idle), .wr_sel(tim_sel), .wr_val(tim_val),
    .tim(tim)
  );

  ow_slot_ctrl #(.TW(TW), .NT(NT)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .tick(tick), .line_s(line_s), .tim(tim),
    .idle(idle), .drive_low(ow_oe),
    .done(done), .rd_bit(rd_bit), .presence(presence), .bus_fault(bus_fault)
  );

  assign cmd_ready = idle;
endmodule

// File: rtl/ow_master_chk.sv
module ow_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic       done,
  input logic       presence,
  input logic       bus_fault,
  input logic       ow_oe,
  input logic       line_s
);
  // R8: never pull the line while idle
  a_r8_oe_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ow_oe |-> !cmd_ready);

  // R8: done is a single-clock pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done coincides with idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  // R8: an accepted command that is not refused makes the engine busy
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !(cmd_op == 2'd0 && !line_s)) |=> !cmd_ready);

  // R5: reset on a low line is refused at once without driving
  a_r5_precheck: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'd0 && !line_s) |=> (done && bus_fault && !ow_oe));

  // R7: a fault never reports a device
  a_r7_fault_no_presence: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fault |-> !presence);
endmodule

bind ow_master ow_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .done(done), .presence(presence), .bus_fault(bus_fault),
  .ow_oe(ow_oe), .line_s(line_s)
);

// File: tb/tb_ow_master.sv
module tb_ow_master;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int TW = 16;

  // expected timing values after reset (R9)
  localparam int T_SLOT = 65, T_LOW1 = 8, T_LOW0 = 60, T_REC = 5, T_LOWR = 5;
  localparam int T_RDV = 15, T_RSTL = 480, T_PDH = 15, T_PDL = 60, T_RSTH = 480;
  localparam int T_WR  = T_SLOT + T_REC;
  localparam int T_RST = T_RSTL + T_RSTH;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] lo_us;
    logic [15:0] hi_us;
    logic [15:0] low_us;
    logic [15:0] tot_us;
    logic        bit_e;
    logic        pres_e;
    logic        flt_e;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 16'd0,   16'd0,    16'(T_LOW1), 16'(T_WR),  1'b0, 1'b0, 1'b0}, // R1
    '{2'd2, 16'd0,   16'd0,    16'(T_LOW0), 16'(T_WR),  1'b0, 1'b0, 1'b0}, // R2
    '{2'd3, 16'd0,   16'd0,    16'(T_LOWR), 16'(T_WR),  1'b1, 1'b0, 1'b0}, // R3 no device hold
    '{2'd3, 16'd0,   16'd3,    16'(T_LOWR), 16'(T_WR),  1'b1, 1'b0, 1'b0}, // R3
    '{2'd3, 16'd0,   16'd14,   16'(T_LOWR), 16'(T_WR),  1'b1, 1'b0, 1'b0}, // R3 just before tRDV
    '{2'd3, 16'd0,   16'd16,   16'(T_LOWR), 16'(T_WR),  1'b0, 1'b0, 1'b0}, // R3 just after tRDV
    '{2'd3, 16'd0,   16'd100,  16'(T_LOWR), 16'(T_WR),  1'b0, 1'b0, 1'b0}, // R4 held past slot
    '{2'd0, 16'd500, 16'd600,  16'(T_RSTL), 16'(T_RST), 1'b0, 1'b1, 1'b0}, // R6 present
    '{2'd0, 16'd0,   16'd0,    16'(T_RSTL), 16'(T_RST), 1'b0, 1'b0, 1'b0}, // R6 absent
    '{2'd0, 16'd500, 16'd1000, 16'(T_RSTL), 16'(T_RST), 1'b0, 1'b0, 1'b1}, // R7 stuck after window
    '{2'd2, 16'd0,   16'd0,    16'(T_LOW0), 16'(T_WR),  1'b0, 1'b0, 1'b0}  // R2 after fault
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'd0;
  logic          tim_we = 1'b0;
  logic [3:0]    tim_sel = 4'd0;
  logic [TW-1:0] tim_val = '0;
  logic          done, rd_bit, presence, bus_fault, ow_oe, ow_in;

  int  checks = 0;
  int  errors = 0;
  int  s_lo = 0, s_hi = 0;
  logic force_low = 1'b0;
  int  scnt = 1000000;
  logic oe_q = 1'b0;
  logic dev_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  ow_master #(.CLKS_PER_US(N), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .tim_we(tim_we), .tim_sel(tim_sel), .tim_val(tim_val),
    .done(done), .rd_bit(rd_bit), .presence(presence), .bus_fault(bus_fault),
    .ow_oe(ow_oe), .ow_in(ow_in)
  );

  // device model: time measured in clocks from the first pull of a slot
  always @(negedge clk) begin
    if (ow_oe && !oe_q)      scnt <= 0;
    else if (scnt < 1000000) scnt <= scnt + 1;
    oe_q <= ow_oe;
  end
  assign dev_low = (scnt >= s_lo * N) && (scnt < s_hi * N);
  assign ow_in   = !(ow_oe || dev_low || force_low);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_tim(input int sel, input int val);
    @(negedge clk);
    tim_we = 1'b1; tim_sel = 4'(sel); tim_val = TW'(val);
    @(negedge clk);
    tim_we = 1'b0;
  endtask

  // issues one command; counts clocks of drive and clocks until done
  task automatic run_cmd(input logic [1:0] op, input bit mid_wr,
                         output int low_clk, output int total, output int rdy_mid);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    low_clk = 0; total = 0; rdy_mid = -1;
    while (!done && total < 20000) begin
      if (ow_oe) low_clk++;
      if (total == 1) rdy_mid = int'(cmd_ready);
      if (mid_wr && total == 50) begin
        tim_we = 1'b1; tim_sel = 4'd0; tim_val = TW'(200);
      end
      if (total == 51) tim_we = 1'b0;
      total++;
      @(negedge clk);
    end
    tim_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lw, tt, rm;
    repeat (3) @(negedge clk);
    // R11: state during reset
    check("R11 oe", int'(ow_oe), 0);
    check("R11 ready", int'(cmd_ready), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 done", int'(done), 0);
    check("R11 flags", int'({rd_bit, presence, bus_fault}), 0);
    check("R11 ready after", int'(cmd_ready), 1);

    for (int i = 0; i < NV; i++) begin
      s_lo = int'(VECS[i].lo_us);
      s_hi = int'(VECS[i].hi_us);
      run_cmd(VECS[i].op, 1'b0, lw, tt, rm);
      check($sformatf("R1/R2/R3/R6 drive width v%0d", i), lw, int'(VECS[i].low_us) * N);
      check($sformatf("R4/R6 completion v%0d", i), tt, int'(VECS[i].tot_us) * N);
      check($sformatf("R8 busy v%0d", i), rm, 0);
      if (VECS[i].op == 2'd3)
        check($sformatf("R3 read bit v%0d", i), int'(rd_bit), int'(VECS[i].bit_e));
      if (VECS[i].op == 2'd0) begin
        check($sformatf("R6 presence v%0d", i), int'(presence), int'(VECS[i].pres_e));
        check($sformatf("R7 fault v%0d", i), int'(bus_fault), int'(VECS[i].flt_e));
      end
      @(negedge clk);
      check($sformatf("R8 done width v%0d", i), int'(done), 0);
      repeat (200) @(negedge clk);
    end

    // R5: shorted line refuses the reset
    s_lo = 0; s_hi = 0;
    force_low = 1'b1;
    repeat (4) @(negedge clk);
    run_cmd(2'd0, 1'b0, lw, tt, rm);
    check("R5 no drive", lw, 0);
    check("R5 immediate done", tt, 0);
    check("R5 fault", int'(bus_fault), 1);
    check("R5 presence", int'(presence), 0);
    force_low = 1'b0;
    repeat (10) @(negedge clk);

    // R9: idle write to index 1 (tLOW1) changes the next slot
    set_tim(1, 10);
    run_cmd(2'd1, 1'b0, lw, tt, rm);
    check("R9 new tLOW1", lw, 10 * N);
    check("R9 slot unchanged", tt, T_WR * N);

    // R10: write to tSLOT during a slot is dropped
    run_cmd(2'd2, 1'b1, lw, tt, rm);
    check("R10 current slot", tt, T_WR * N);
    repeat (5) @(negedge clk);
    run_cmd(2'd1, 1'b0, lw, tt, rm);
    check("R10 later slot", tt, T_WR * N);
    check("R10 tLOW1 kept", lw, 10 * N);

    // R9: default index 0 write while idle does take effect
    set_tim(0, 30);
    run_cmd(2'd1, 1'b0, lw, tt, rm);
    check("R9 new tSLOT", tt, (30 + T_REC) * N);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule